// File: doc/BRIEF.md
# Random Start Trigger Generator

This block starts a reflex test. When the operator presses the arm button, it waits for a pseudo-random time and then issues the one-cycle trigger. That trigger lights the indicator lamp and starts the reaction counter elsewhere in the system.

An 8-bit linear feedback shift register runs freely, one step per clock. At the press, its two low bits pick a whole-second delay of 0, 1 or 2 s. A fixed half-second offset is added to that, so the total wait is never zero and always stays below 3 s. A first one-shot stage counts the wait in millisecond ticks. A second one-shot stage turns the end of the wait into a clean single-cycle pulse.

Pressing arm again while a wait is running starts a new wait, with a newly sampled delay. The block has no data stream, so no port carries back-pressure. The trigger is an event lasting one cycle, and every pin is a plain control or status signal.

Top module: `rand_start_trigger`

## Requirements
- R1: While `rst_n` is low, `start_pulse` and `busy` are 0 and `delay_sec` is 0. A reset in the middle of a wait drops that wait, and no trigger follows from it.
- R2: The random source is an 8-bit register.
  - `rst_n` loads it with 8'h01.
  - After reset it steps on every clock edge: next = {q[6:0], q[7]^q[5]^q[4]^q[3]}. This gives a maximal sequence of 255 states.
  - It never holds all zeros.
- R3: On the clock edge where `arm_press` is high, the register value before that edge's step is sampled. Its bits [1:0] give the delay in seconds: 0→0, 1→1, 2→2, 3→2. From the next cycle, `delay_sec` shows that value. It holds it until the next press and never shows 3.
- R4: The wait lasts `delay_sec`*1000 + 500 millisecond ticks. Only ticks seen on clock edges after the press edge are counted.
- R5: Let the clock edge that consumes the final tick be edge E. `start_pulse` is high for exactly one cycle: the cycle that follows the edge after E.
- R6: `busy` is high from the cycle after a press through the cycle in which `start_pulse` is high. It is low in the cycle after the pulse.
- R7: A press while a wait is running restarts the wait with a freshly sampled delay, and the earlier wait never produces a pulse. This holds even when the press lands on the edge that consumes the final tick, or on the edge between expiry and the pulse.
- R8: `ms_tick` is low in a cycle → the countdown does not move on that cycle's edge. The wait is measured in ticks, not clock cycles.
- R9: `start_pulse` is only ever issued once per press. With no press, it stays low however long the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| arm_press | input | 1 | Arm button press, one cycle per press |
| start_pulse | output | 1 | Single-cycle trigger at the end of the wait |
| busy | output | 1 | A wait or its trigger is in progress |
| delay_sec | output | 2 | Whole-second part of the current delay (0 to 2) |

## Verification
The bench runs its own model of the shift register. It waits until the model predicts each of the four raw low-bit patterns, then presses. A design that sampled after the step, mapped the value 3 wrongly, or used the wrong taps would show a `delay_sec` or a pulse time that does not match. Presses are aimed at the exact edge that consumes the last tick, and at the edge between expiry and the pulse. A design that let the old wait finish would emit a stray pulse. A design whose second stage did not clear on restart would also emit one. A phase with a tick only every third cycle catches a countdown that runs on clock cycles. A reset in mid-wait and a long idle stretch catch triggers that arrive without a press.

// File: rtl/rand_start_trigger_pkg.sv
package rand_start_trigger_pkg;

  localparam int SEL_W = 2;

  // Map the two raw random bits onto 0..2 whole seconds.
  function automatic logic [SEL_W-1:0] fold_sel(input logic [SEL_W-1:0] raw);
    return (raw == 2'd3) ? 2'd2 : raw;
  endfunction

endpackage

// File: rtl/rand_start_trigger_lfsr.sv
module rand_start_trigger_lfsr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   TAPS = 8'hB8,
  parameter logic [W-1:0]   SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic fb;

  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED;
    end else if (state == '0) begin
      state <= SEED;             // lock-up guard
    end else begin
      state <= {state[W-2:0], fb};
    end
  end

endmodule

// File: rtl/rand_start_trigger_delay.sv
// First one-shot: counts a loaded number of ticks, then raises a level.
module rand_start_trigger_delay #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             active,
  output logic             expired
);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      active  <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      remain  <= load_val;
      active  <= 1'b1;
      expired <= 1'b0;
    end else if (active && tick) begin
      if (remain <= CNT_W'(1)) begin
        remain  <= '0;
        active  <= 1'b0;
        expired <= 1'b1;
      end else begin
        remain <= remain - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/rand_start_trigger_pulse.sv
// Second one-shot: one registered pulse per rising edge of the level input.
module rand_start_trigger_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic cancel,
  input  logic level,
  output logic pulse
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      pulse <= 1'b0;
    end else if (cancel) begin
      seen  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      seen  <= level;
      pulse <= level & ~seen;
    end
  end

endmodule

// File: rtl/rand_start_trigger.sv
module rand_start_trigger
  import rand_start_trigger_pkg::*;
#(
  parameter int              LFSR_W        = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS   = 8'hB8,
  parameter logic [LFSR_W-1:0] LFSR_SEED   = 8'h01,
  parameter int              TICKS_PER_SEC = 1000,
  parameter int              OFFSET_TICKS  = 500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic             arm_press,
  output logic             start_pulse,
  output logic             busy,
  output logic [SEL_W-1:0] delay_sec
);

  localparam int MAX_SEC   = 2;
  localparam int MAX_DELAY = MAX_SEC * TICKS_PER_SEC + OFFSET_TICKS;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);

  logic [LFSR_W-1:0] lfsr_q;
  logic [SEL_W-1:0]  sel_now;
  logic [CNT_W-1:0]  load_val;
  logic              wait_active;
  logic              wait_expired;

  rand_start_trigger_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr_q)
  );

  assign sel_now  = fold_sel(lfsr_q[SEL_W-1:0]);
  assign load_val = CNT_W'(int'(sel_now) * TICKS_PER_SEC + OFFSET_TICKS);

  rand_start_trigger_delay #(
    .CNT_W (CNT_W)
  ) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (arm_press),
    .load_val (load_val),
    .tick     (ms_tick),
    .active   (wait_active),
    .expired  (wait_expired)
  );

  rand_start_trigger_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .cancel (arm_press),
    .level  (wait_expired & ~wait_active),
    .pulse  (start_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delay_sec <= '0;
      busy      <= 1'b0;
    end else begin
      if (arm_press) begin
        delay_sec <= sel_now;
      end
      if (arm_press) begin
        busy <= 1'b1;
      end else if (start_pulse) begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rand_start_trigger_chk.sv
module rand_start_trigger_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         arm_press,
  input logic         start_pulse,
  input logic         busy,
  input logic [1:0]   delay_sec,
  input logic [W-1:0] lfsr_q
);

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R5
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0); // R2
  AST_SEC_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
    delay_sec != 2'd3); // R3
  AST_SEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_press |=> $stable(delay_sec)); // R3
  AST_BUSY_ON_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    arm_press |=> busy); // R6
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && !arm_press) |=> !busy); // R6
  AST_PRESS_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_press |=> !start_pulse); // R7
  AST_PULSE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy); // R9

endmodule

bind rand_start_trigger rand_start_trigger_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arm_press   (arm_press),
  .start_pulse (start_pulse),
  .busy        (busy),
  .delay_sec   (delay_sec),
  .lfsr_q      (lfsr_q)
);

// File: tb/sim_rand_start_trigger.sv
module sim_rand_start_trigger;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       arm_press = 1'b0;
  logic       start_pulse;
  logic       busy;
  logic [1:0] delay_sec;

  typedef struct {
    int edge_at;
    int sec;
  } exp_t;

  exp_t       q[$];
  int         edge_n = 0;
  logic [7:0] lfsr_m = 8'h01;
  int         tick_div = 1;
  int         checks = 0;
  int         fails = 0;
  int         pulses_seen = 0;
  int         pulses_expected = 0;
  int         last_ed = 0;
  bit         busy_low_due = 1'b0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  rand_start_trigger u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .arm_press   (arm_press),
    .start_pulse (start_pulse),
    .busy        (busy),
    .delay_sec   (delay_sec)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference random source, from R2.
  always @(posedge clk) begin
    edge_n++;
    if (!rst_n) lfsr_m = 8'h01;
    else        lfsr_m = {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
  end

  // Tick generator: high before edge e when e % tick_div == 0.
  always @(negedge clk) ms_tick = ((edge_n + 1) % tick_div) == 0;

  // Monitor: pops expectations as pulses appear.
  always @(negedge clk) begin
    if (busy_low_due) begin
      chk(busy == 1'b0, "R6", "busy after pulse", busy, 0);
      busy_low_due = 1'b0;
    end
    if (start_pulse) begin
      pulses_seen++;
      if (q.size() == 0) begin
        chk(1'b0, "R9", "pulse with no pending press (edge)", edge_n, -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(edge_n == e.edge_at, "R4 R5", "pulse timing (edge)", edge_n, e.edge_at);
        chk(int'(delay_sec) == e.sec, "R3", "delay_sec at pulse", delay_sec, e.sec);
        chk(busy == 1'b1, "R6", "busy during pulse", busy, 1);
        busy_low_due = 1'b1;
      end
    end
  end

  // Driver: want < 0 presses at once, else waits for that raw low-bit pattern.
  task automatic press(input int want);
    int e, cnt, d, sec;
    @(negedge clk);
    while (want >= 0 && int'(lfsr_m[1:0]) != want) @(negedge clk);
    sec = (lfsr_m[1:0] == 2'd3) ? 2 : int'(lfsr_m[1:0]);
    d   = sec * 1000 + 500;
    e   = edge_n + 1;
    cnt = 0;
    while (cnt < d) begin
      e++;
      if (e % tick_div == 0) cnt++;
    end
    q.delete();
    q.push_back('{e + 1, sec});
    last_ed = e;
    arm_press = 1'b1;
    @(negedge clk);
    arm_press = 1'b0;
    chk(busy == 1'b1, "R6", "busy after press", busy, 1);
    chk(int'(delay_sec) == sec, "R3", "delay_sec after press", delay_sec, sec);
  endtask

  task automatic wait_done();
    while (q.size() != 0) @(negedge clk);
    pulses_expected++;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(start_pulse == 1'b0, "R1", "start_pulse in reset", start_pulse, 0);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(delay_sec == 2'd0, "R1", "delay_sec in reset", delay_sec, 0);
    rst_n = 1'b1;

    // R2 R3 R4: every raw pattern, including the fold of 3.
    press(0); wait_done();
    press(1); wait_done();
    press(2); wait_done();
    press(3); wait_done();

    // R7: restart mid-wait.
    press(2);
    repeat (300) @(negedge clk);
    press(0); wait_done();

    // R7: press on the edge that consumes the final tick.
    press(1);
    while (edge_n + 2 != last_ed) @(negedge clk);
    press(-1); wait_done();

    // R7: press on the edge between expiry and the pulse.
    press(0);
    while (edge_n + 2 != last_ed + 1) @(negedge clk);
    press(-1); wait_done();

    // R8: sparse ticks.
    tick_div = 3;
    press(1); wait_done();
    tick_div = 1;

    // R1: reset during a wait drops it.
    press(2);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    q.delete();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in mid-wait reset", busy, 0);
    chk(delay_sec == 2'd0, "R1", "delay_sec in mid-wait reset", delay_sec, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: long idle, no pulse.
    repeat (3000) @(negedge clk);
    chk(pulses_seen == pulses_expected, "R9", "pulse count", pulses_seen, pulses_expected);

    // R2: the sequence continues correctly after reset.
    press(3); wait_done();

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule